// File: doc/BRIEF.md
# Fast Off power-management countdown timer

This block counts down an idle interval for system power management. Software writes a reload count through a load strobe. After that the timer decrements once per tick. Whenever the system shows activity, a restart strobe brings the count back to the stored reload value. A 2-bit granularity code picks the tick. The tick can be every clock, one millisecond, one minute, or no tick at all (the timer is frozen). The millisecond and minute ticks come from fixed clock counts. The real tick length therefore scales with the clock frequency. At 33 MHz they are about 1 ms and 1 minute. At 30 MHz they are about 1.1 ms and 1.1 minutes. At 25 MHz they are about 1.32 ms and 1.32 minutes.

When a tick takes the count from one to zero, the block emits a one-cycle expiry pulse, which goes to the system management interrupt request logic. The timer then stays at zero until it is loaded or restarted again.

The count logic is a two-state machine with these states:
- `ST_IDLE`: the count is zero.
- `ST_COUNT`: the count is nonzero.

Each cycle takes one named transition:
- `TR_LOAD`: a load strobe writes a new value.
- `TR_RESTART`: a restart strobe copies the stored reload value into the count.
- `TR_STEP`: a tick decrements a count above one and stays in `ST_COUNT`.
- `TR_LAST`: a tick on a count of one moves to `ST_IDLE` and fires the expiry pulse.
- `TR_HOLD`: nothing changes.

A load or restart leads to `ST_COUNT` when the value it writes is nonzero, and to `ST_IDLE` when that value is zero.

Top module: `fast_off_timer`

## Requirements
- R1: After reset the count is 0, the expiry output is 0, the stored reload value is 0 and both prescalers are cleared.
- R2: With granularity code 2'b10 the count decrements by one on every clock edge while it is nonzero.
- R3: With granularity code 2'b11 the count decrements once every MS_DIV clocks. The default MS_DIV is 33000, which is about 1 ms at 33 MHz.
- R4: With granularity code 2'b00 the count decrements once every MS_DIV*MIN_DIV clocks. The default MIN_DIV is 60000, which is about one minute at 33 MHz.
- R5: Granularity code 2'b01 (the disabled code) freezes the count and both prescalers, and no expiry is produced. When counting resumes, the prescalers continue from where they stopped.
- R6: The expiry output is high for exactly one cycle. That cycle is the first one in which the count output shows 0 after a tick on a count of 1.
- R7: At zero the count stays zero and ticks have no effect. Loading or restarting to a value of 0 produces no expiry.
- R8: A load strobe writes load_val into both the reload register and the count, and clears both prescalers. The new count is visible in the cycle after the strobe.
- R9: A restart strobe copies the stored reload value into the count and clears both prescalers. When load and restart come together, the load value is used.
- R10: A tick in the same cycle as a load or restart is dropped. It neither decrements the count nor fires an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock (bus clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| gran_sel | input | 2 | Granularity code: 00 minute, 01 off, 10 per clock, 11 millisecond |
| load_stb | input | 1 | Write strobe for the reload value |
| load_val | input | CNT_W | Reload count to write |
| restart_stb | input | 1 | System activity; restarts the countdown |
| expire_pulse | output | 1 | One-cycle expiry event |
| count_out | output | CNT_W | Current count |

## Verification
Two situations are the hardest to reach from the ports. The first is a freeze that lands part-way through a prescale period. The bench parameterises the prescalers down to a few clocks and loads a count in millisecond mode. It lets two prescale clocks pass, holds the disabled code for many cycles, and then resumes. The next decrement must arrive after the remaining prescale clocks, not after a full period. The second is a load or restart that lands exactly on a prescaler wrap. The bench reaches it with restarts timed against the millisecond and minute periods. A per-cycle behavioural model shows whether the tick was dropped.

// File: rtl/fot_pkg.sv
package fot_pkg;

    typedef enum logic [1:0] {
        GR_MINUTE = 2'b00,
        GR_OFF    = 2'b01,
        GR_CLOCK  = 2'b10,
        GR_MILLI  = 2'b11
    } gran_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } state_e;

    typedef enum logic [2:0] {
        TR_HOLD,
        TR_LOAD,
        TR_RESTART,
        TR_STEP,
        TR_LAST
    } trans_e;

endpackage

// File: rtl/fot_divider.sv
module fot_divider #(
    parameter int DIV = 33000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic wrap
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    assign wrap = adv && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fot_tick_sel.sv
module fot_tick_sel
    import fot_pkg::*;
(
    input  gran_e gran,
    input  logic  clr,
    input  logic  ms_wrap,
    input  logic  min_wrap,
    output logic  ms_adv,
    output logic  min_adv,
    output logic  tick
);
    always_comb begin
        ms_adv  = 1'b0;
        min_adv = 1'b0;
        tick    = 1'b0;
        unique case (gran)
            GR_OFF: begin
            end
            GR_CLOCK: begin
                tick = 1'b1;
            end
            GR_MILLI: begin
                ms_adv = !clr;
                tick   = ms_wrap;
            end
            GR_MINUTE: begin
                ms_adv  = !clr;
                min_adv = ms_wrap;
                tick    = min_wrap;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/fot_counter.sv
module fot_counter
    import fot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_stb,
    input  logic             restart_stb,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    state_e           state_q, state_d;
    trans_e           trans;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] reload_q, reload_d;
    logic             expire_q;

    // transition choice
    always_comb begin
        if (load_stb) begin
            trans = TR_LOAD;
        end else if (restart_stb) begin
            trans = TR_RESTART;
        end else if (tick && state_q == ST_COUNT) begin
            trans = (count_q == CNT_W'(1)) ? TR_LAST : TR_STEP;
        end else begin
            trans = TR_HOLD;
        end
    end

    // next state and data
    always_comb begin
        state_d  = state_q;
        count_d  = count_q;
        reload_d = reload_q;
        unique case (trans)
            TR_LOAD: begin
                reload_d = load_val;
                count_d  = load_val;
                state_d  = (load_val != '0) ? ST_COUNT : ST_IDLE;
            end
            TR_RESTART: begin
                count_d = reload_q;
                state_d = (reload_q != '0) ? ST_COUNT : ST_IDLE;
            end
            TR_STEP: begin
                count_d = count_q - 1'b1;
            end
            TR_LAST: begin
                count_d = '0;
                state_d = ST_IDLE;
            end
            TR_HOLD: begin
            end
            default: begin
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            state_q  <= state_d;
            count_q  <= count_d;
            reload_q <= reload_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire_q <= 1'b0;
        end else begin
            expire_q <= (trans == TR_LAST);
        end
    end

    assign count  = count_q;
    assign expire = expire_q;
endmodule

// File: rtl/fast_off_timer.sv
module fast_off_timer
    import fot_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MS_DIV  = 33000,
    parameter int MIN_DIV = 60000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       gran_sel,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart_stb,
    output logic             expire_pulse,
    output logic [CNT_W-1:0] count_out
);
    logic clr;
    logic ms_adv, min_adv, ms_wrap, min_wrap, tick;

    assign clr = load_stb || restart_stb;

    fot_tick_sel u_sel (
        .gran     (gran_e'(gran_sel)),
        .clr      (clr),
        .ms_wrap  (ms_wrap),
        .min_wrap (min_wrap),
        .ms_adv   (ms_adv),
        .min_adv  (min_adv),
        .tick     (tick)
    );

    fot_divider #(.DIV(MS_DIV)) u_ms (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (ms_adv),
        .wrap  (ms_wrap)
    );

    fot_divider #(.DIV(MIN_DIV)) u_min (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (min_adv),
        .wrap  (min_wrap)
    );

    fot_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .load_stb    (load_stb),
        .restart_stb (restart_stb),
        .load_val    (load_val),
        .count       (count_out),
        .expire      (expire_pulse)
    );
endmodule

// File: rtl/fot_chk.sv
module fot_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       gran_sel,
    input logic             load_stb,
    input logic [CNT_W-1:0] load_val,
    input logic             restart_stb,
    input logic             expire_pulse,
    input logic [CNT_W-1:0] count_out
);
    // R6
    expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |=> !expire_pulse);

    // R6
    expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> (count_out == '0 && $past(count_out) == CNT_W'(1)));

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gran_sel == 2'b01 && !load_stb && !restart_stb)
            |=> ($stable(count_out) && !expire_pulse));

    // R7
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_out == '0 && !load_stb && !restart_stb) |=> (count_out == '0));

    // R2
    per_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gran_sel == 2'b10 && !load_stb && !restart_stb && count_out != '0)
            |=> (count_out == $past(count_out) - 1'b1));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (count_out == $past(load_val) && !expire_pulse));
endmodule

bind fast_off_timer fot_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gran_sel     (gran_sel),
    .load_stb     (load_stb),
    .load_val     (load_val),
    .restart_stb  (restart_stb),
    .expire_pulse (expire_pulse),
    .count_out    (count_out)
);

// File: tb/sim_fast_off_timer.sv
`timescale 1ns/1ps
module sim_fast_off_timer;
    localparam int CW = 8;
    localparam int MS = 4;
    localparam int MN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    gran_sel = 2'b01;
    logic          load_stb = 1'b0;
    logic [CW-1:0] load_val = '0;
    logic          restart_stb = 1'b0;
    logic          expire_pulse;
    logic [CW-1:0] count_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0, m_rel = 0, m_ms = 0, m_mn = 0;
    bit m_exp = 0;

    always #2 clk = ~clk;

    fast_off_timer #(.CNT_W(CW), .MS_DIV(MS), .MIN_DIV(MN)) u0 (
        .clk(clk), .rst_n(rst_n), .gran_sel(gran_sel), .load_stb(load_stb),
        .load_val(load_val), .restart_stb(restart_stb),
        .expire_pulse(expire_pulse), .count_out(count_out)
    );

    always @(posedge clk) begin
        bit tk;
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_ms = 0; m_mn = 0; m_exp = 0;
        end else begin
            m_exp = 0;
            if (load_stb || restart_stb) begin
                if (load_stb) m_rel = load_val;
                m_cnt = m_rel; m_ms = 0; m_mn = 0;
            end else begin
                tk = 0;
                case (gran_sel)
                    2'b10: tk = 1;
                    2'b11: if (m_ms == MS-1) begin m_ms = 0; tk = 1; end else m_ms++;
                    2'b00: if (m_ms == MS-1) begin
                               m_ms = 0;
                               if (m_mn == MN-1) begin m_mn = 0; tk = 1; end else m_mn++;
                           end else m_ms++;
                    default: ;
                endcase
                if (tk && m_cnt > 0) begin
                    m_cnt--;
                    if (m_cnt == 0) m_exp = 1;
                end
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check(count_out == CW'(m_cnt), cur_req, count_out, m_cnt);
        check(expire_pulse == m_exp, cur_req, expire_pulse, m_exp);
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(int v);
        load_stb = 1; load_val = CW'(v);
        step(1);
        load_stb = 0;
    endtask

    task automatic do_restart();
        restart_stb = 1;
        step(1);
        restart_stb = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        step(3);
        // R1 reset state
        check(count_out == 0, "R1", count_out, 0);
        check(expire_pulse == 0, "R1", expire_pulse, 0);
        rst_n = 1;
        step(2);
        cur_req = "R1";
        do_restart();
        check(count_out == 0, "R1", count_out, 0);

        // R2 per clock, R6 expiry
        cur_req = "R2"; gran_sel = 2'b10;
        do_load(5);
        step(4);
        check(count_out == 1, "R2", count_out, 1);
        step(1);
        check(count_out == 0 && expire_pulse, "R6", {count_out, expire_pulse}, 1);
        step(1);
        check(!expire_pulse, "R6", expire_pulse, 0);
        cur_req = "R7"; step(6);
        check(count_out == 0, "R7", count_out, 0);
        do_load(0);
        check(!expire_pulse, "R7", expire_pulse, 0);

        // R3 millisecond ticks
        cur_req = "R3"; gran_sel = 2'b11;
        do_load(3);
        step(MS - 1);
        check(count_out == 3, "R3", count_out, 3);
        step(1);
        check(count_out == 2, "R3", count_out, 2);
        step(3 * MS);

        // R4 minute ticks
        cur_req = "R4"; gran_sel = 2'b00;
        do_load(2);
        step(MS * MN - 1);
        check(count_out == 2, "R4", count_out, 2);
        step(1);
        check(count_out == 1, "R4", count_out, 1);
        step(MS * MN + 3);

        // R5 freeze mid-prescale
        cur_req = "R5"; gran_sel = 2'b11;
        do_load(4);
        step(2);
        gran_sel = 2'b01;
        step(10);
        check(count_out == 4, "R5", count_out, 4);
        gran_sel = 2'b11;
        step(1);
        check(count_out == 4, "R5", count_out, 4);
        step(1);
        check(count_out == 3, "R5", count_out, 3);

        // R9 restart and priority
        cur_req = "R9";
        step(2 * MS);
        do_restart();
        check(count_out == 4, "R9", count_out, 4);
        step(2);
        load_stb = 1; restart_stb = 1; load_val = 9;
        step(1);
        load_stb = 0; restart_stb = 0;
        check(count_out == 9, "R9", count_out, 9);
        do_restart();
        check(count_out == 9, "R8", count_out, 9);

        // R10 strobes on tick edges
        cur_req = "R10"; gran_sel = 2'b10;
        do_load(1);
        check(count_out == 1 && !expire_pulse, "R10", count_out, 1);
        do_restart();
        check(count_out == 1 && !expire_pulse, "R10", count_out, 1);
        gran_sel = 2'b11;
        do_load(6);
        for (int i = 0; i < 6; i++) begin
            step(MS - 1);
            do_restart();
        end
        check(count_out == 6, "R10", count_out, 6);
        gran_sel = 2'b00;
        for (int i = 0; i < 4; i++) begin
            step(MS * MN - 1 - i);
            do_restart();
        end

        // R8 load value in minute mode, prescalers cleared
        cur_req = "R8";
        do_load(2);
        step(MS * MN * 2 + 2);
        check(count_out == 0, "R8", count_out, 0);
        step(3);
        finish_run();
    end
endmodule